// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Unit

This block watches an asynchronous input pin and, when the chosen transition appears on it, records the value of an external free-running counter. The pin first passes through a synchronizer. It can then pass through an optional glitch filter that accepts a new level only after that level has been seen on four consecutive clock samples. A direction bit picks the transition that qualifies: rising or falling. A qualifying transition loads the counter value into the capture register and sets a sticky event flag. Software clears that flag with a one-cycle clear strobe. An interrupt request follows the flag when interrupts are enabled.

The capture register has a second use. When the counter's period is taken from this register, a TOP mode input is held high. In that mode, pin transitions do not touch the register or the flag, and software loads the register through a write strobe.

The glitch filter is a state machine with two states. In FLT_STEADY, the accepted level matches the sample. When a sample differs, the filter goes to FLT_QUALIFY with a run length of 1. In FLT_QUALIFY, a sample that matches the accepted level sends it back to FLT_STEADY. When the run reaches four differing samples, the filter adopts the new level and also returns to FLT_STEADY. The flag logic is a second state machine with two states. A capture moves it from HOLD_EMPTY to HOLD_FULL. In HOLD_FULL, a capture keeps it there. Without a capture, a clear strobe moves it back to HOLD_EMPTY.

Top module: `cap_unit`

## Requirements
- R1: After reset, the capture register is 0 and both the flag and the interrupt request are 0.
- R2: With the filter off, a pin transition first sampled at clock edge k loads into the capture register the counter value present at edge k+2. The flag is also set at edge k+2.
- R3: A direction input of 1 selects rising transitions and 0 selects falling ones. A transition in the other direction leaves the register and the flag unchanged.
- R4: With the filter on, a new level is accepted only when it is seen on four consecutive samples. Pulses of 1 to 3 clocks cause no capture. An accepted transition loads the counter value present at edge k+6, which is four clocks later than with the filter off.
- R5: The flag stays set until a clear strobe. If a capture and a clear fall in the same cycle, the flag stays set.
- R6: The interrupt request equals the flag ANDed with the interrupt enable.
- R7: While TOP mode is high, pin transitions change neither the register nor the flag, and a write strobe loads the write data into the register.
- R8: While TOP mode is low, the write strobe has no effect on the register.
- R9: A capture that occurs while the flag is already set overwrites the register with the new counter value, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 1 | Asynchronous capture pin |
| count_in | input | CNT_W | Live value of the free-running counter |
| rise_sel | input | 1 | 1 selects rising transitions, 0 selects falling |
| filt_en | input | 1 | Enables the four-sample glitch filter |
| top_mode | input | 1 | Register serves as counter TOP: captures are blocked and writes are allowed |
| irq_en | input | 1 | Interrupt enable |
| sw_wr | input | 1 | Software write strobe, effective only in TOP mode |
| sw_wdata | input | CNT_W | Software write data |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| cap_value | output | CNT_W | Capture register |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, two synchronizer stages and a filter length of four. With those values, sweeping pulse widths from 1 to 6 clocks falls on both sides of the filter threshold. The sweep covers every combination of direction and filter setting, so both capture latencies (k+2 and k+6) and the rejection of short pulses are each seen. Targeted sequences then cover a capture and a clear in the same cycle, an overwrite while the flag is set, and software writes in and out of TOP mode.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic {
        FLT_STEADY  = 1'b0,
        FLT_QUALIFY = 1'b1
    } flt_state_t;

    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_t;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter
    import cap_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic lvl_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    flt_state_t     state_q, state_d;
    logic [CW-1:0]  run_q, run_d;
    logic           lvl_q, lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            run_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            FLT_STEADY: begin
                if (d_in != lvl_q) begin
                    if (LAST == '0) begin
                        lvl_d = d_in;
                    end else begin
                        state_d = FLT_QUALIFY;
                        run_d   = CW'(1);
                    end
                end
            end
            FLT_QUALIFY: begin
                if (d_in == lvl_q) begin
                    state_d = FLT_STEADY;
                    run_d   = '0;
                end else if (run_q == LAST) begin
                    state_d = FLT_STEADY;
                    run_d   = '0;
                    lvl_d   = d_in;
                end else begin
                    run_d = run_q + CW'(1);
                end
            end
            default: begin
                state_d = FLT_STEADY;
                run_d   = '0;
            end
        endcase
    end

    assign lvl_o = lvl_q;

    // R4: the accepted level only moves after a full run of differing samples
    assert_filter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == FLT_QUALIFY && run_q == LAST && d_in != lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/cap_edge.sv
module cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_raw,
    input  logic lvl_flt,
    input  logic filt_en,
    input  logic rise_sel,
    output logic cap_evt
);
    logic lvl_sel;
    logic prev_q;

    assign lvl_sel = filt_en ? lvl_flt : lvl_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_sel;
    end

    assign cap_evt = (lvl_sel != prev_q) && (lvl_sel == rise_sel);

    // R3: only one direction qualifies, so events never come back to back
    assert_single_cycle_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> !cap_evt);
endmodule

// File: rtl/cap_hold.sv
module cap_hold
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] count_in,
    input  logic             top_mode,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_wdata,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             cap_irq
);
    hold_state_t      state_q, state_d;
    logic [CNT_W-1:0] value_q;
    logic             take;

    assign take = cap_evt && !top_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: if (take) state_d = HOLD_FULL;
            HOLD_FULL:  if (!take && flag_clr) state_d = HOLD_EMPTY;
            default:    state_d = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  value_q <= '0;
        else if (top_mode && sw_wr)  value_q <= sw_wdata;
        else if (take)               value_q <= count_in;
    end

    always_comb begin
        cap_value = value_q;
        cap_flag  = (state_q == HOLD_FULL);
        cap_irq   = cap_flag && irq_en;
    end

    // R2, R9: a capture loads the counter value of its own cycle
    assert_capture_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (value_q == $past(count_in)));
    // R5: flag is sticky without a clear
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HOLD_FULL && !flag_clr) |=> (state_q == HOLD_FULL));
    // R5: capture wins over clear
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !top_mode && flag_clr) |=> (state_q == HOLD_FULL));
    // R7: in TOP mode only software writes move the register
    assert_top_blocks_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode && !sw_wr) |=> $stable(value_q));
endmodule

// File: rtl/cap_unit.sv
module cap_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic [CNT_W-1:0] count_in,
    input  logic             rise_sel,
    input  logic             filt_en,
    input  logic             top_mode,
    input  logic             irq_en,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             cap_irq
);
    logic pin_s;
    logic pin_f;
    logic evt;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .q_sync  (pin_s)
    );

    cap_filter #(.LEN(FILT_LEN)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_s),
        .lvl_o (pin_f)
    );

    cap_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_raw  (pin_s),
        .lvl_flt  (pin_f),
        .filt_en  (filt_en),
        .rise_sel (rise_sel),
        .cap_evt  (evt)
    );

    cap_hold #(.CNT_W(CNT_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt   (evt),
        .count_in  (count_in),
        .top_mode  (top_mode),
        .sw_wr     (sw_wr),
        .sw_wdata  (sw_wdata),
        .flag_clr  (flag_clr),
        .irq_en    (irq_en),
        .cap_value (cap_value),
        .cap_flag  (cap_flag),
        .cap_irq   (cap_irq)
    );

    // R6: interrupt request never rises without an enable
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !cap_irq);
endmodule

// File: tb/tb_cap_unit.sv
module tb_cap_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin_async = 1'b0;
    logic [W-1:0] count_in = '0;
    logic         rise_sel = 1'b1;
    logic         filt_en = 1'b0;
    logic         top_mode = 1'b0;
    logic         irq_en = 1'b0;
    logic         sw_wr = 1'b0;
    logic [W-1:0] sw_wdata = '0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] cap_value;
    logic         cap_flag;
    logic         cap_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) count_in <= count_in + W'(1);

    cap_unit dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .count_in(count_in),
        .rise_sel(rise_sel), .filt_en(filt_en), .top_mode(top_mode), .irq_en(irq_en),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .flag_clr(flag_clr),
        .cap_value(cap_value), .cap_flag(cap_flag), .cap_irq(cap_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        wait_n(1);
        flag_clr = 1'b0;
        wait_n(1);
    endtask

    task automatic run_case(input int sel, input int f, input int w);
        logic [W-1:0] old, v, exp_val;
        bit acc;
        rise_sel = sel[0];
        filt_en  = f[0];
        wait_n(10);
        clear_flag();
        old = cap_value;
        v = count_in;
        pin_async = 1'b1;
        wait_n(w);
        pin_async = 1'b0;
        wait_n(14);
        acc = (f == 0) || (w >= 4);
        if (sel == 1) exp_val = v + W'((f != 0) ? 6 : 2);
        else          exp_val = v + W'(w) + W'((f != 0) ? 6 : 2);
        if (!acc) exp_val = old;
        if (f != 0) begin
            check($sformatf("R4 flag sel=%0d w=%0d", sel, w), 32'(cap_flag), 32'(acc));
            check($sformatf("R4 value sel=%0d w=%0d", sel, w), 32'(cap_value), 32'(exp_val));
        end else begin
            check($sformatf("R2 R3 flag sel=%0d w=%0d", sel, w), 32'(cap_flag), 32'(acc));
            check($sformatf("R2 R3 value sel=%0d w=%0d", sel, w), 32'(cap_value), 32'(exp_val));
        end
    endtask

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] held;
        wait_n(3);
        check("R1 value", 32'(cap_value), 32'h0);
        check("R1 flag", 32'(cap_flag), 32'h0);
        check("R1 irq", 32'(cap_irq), 32'h0);
        rst_n = 1'b1;
        wait_n(4);

        for (int sel = 0; sel < 2; sel++)
            for (int f = 0; f < 2; f++)
                for (int w = 1; w <= 6; w++)
                    run_case(sel, f, w);

        // R3: opposite edge is ignored (falling edge with rising selected)
        rise_sel = 1'b1; filt_en = 1'b0;
        pin_async = 1'b1; wait_n(10);
        clear_flag();
        held = cap_value;
        pin_async = 1'b0; wait_n(10);
        check("R3 opposite edge flag", 32'(cap_flag), 32'h0);
        check("R3 opposite edge value", 32'(cap_value), 32'(held));

        // R6: interrupt follows flag and enable
        v = count_in; pin_async = 1'b1; wait_n(6);
        check("R6 irq disabled", 32'(cap_irq), 32'h0);
        irq_en = 1'b1; wait_n(1);
        check("R6 irq enabled", 32'(cap_irq), 32'h1);

        // R9: overwrite while flag set
        pin_async = 1'b0; wait_n(6);
        v = count_in; pin_async = 1'b1; wait_n(8);
        check("R9 overwrite value", 32'(cap_value), 32'(v + W'(2)));
        check("R9 flag stays", 32'(cap_flag), 32'h1);

        // R5: clear alone drops the flag, clear with capture keeps it
        clear_flag();
        check("R5 cleared", 32'(cap_flag), 32'h0);
        check("R6 irq after clear", 32'(cap_irq), 32'h0);
        pin_async = 1'b0; wait_n(8);
        v = count_in; pin_async = 1'b1;
        wait_n(2);
        flag_clr = 1'b1; wait_n(1); flag_clr = 1'b0;
        check("R5 set wins over clear", 32'(cap_flag), 32'h1);
        wait_n(4);
        check("R5 sticky", 32'(cap_flag), 32'h1);
        check("R5 capture value", 32'(cap_value), 32'(v + W'(2)));

        // R8: write strobe outside TOP mode ignored
        held = cap_value;
        sw_wdata = 16'h1234; sw_wr = 1'b1; wait_n(1); sw_wr = 1'b0; wait_n(1);
        check("R8 write ignored", 32'(cap_value), 32'(held));

        // R7: TOP mode write and blocked capture
        pin_async = 1'b0; wait_n(8);
        clear_flag();
        top_mode = 1'b1;
        sw_wdata = 16'hBEEF; sw_wr = 1'b1; wait_n(1); sw_wr = 1'b0; wait_n(1);
        check("R7 write loads", 32'(cap_value), 32'hBEEF);
        pin_async = 1'b1; wait_n(10);
        check("R7 capture blocked value", 32'(cap_value), 32'hBEEF);
        check("R7 capture blocked flag", 32'(cap_flag), 32'h0);
        top_mode = 1'b0;
        wait_n(2);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule